// File: doc/BRIEF.md
# Bit-Addressable Internal Data RAM

This block is the directly addressed internal data space of an 8-bit microcontroller core. It holds a 128-byte scratchpad RAM in the lower half of the direct address range. Any direct address in the upper half is passed to an external special-function-register (SFR) port. A byte port serves reads and writes. A register-relative mode on that port folds a 3-bit register number into one of four 8-byte register banks, chosen by a bank-select input.

A separate bit port reads, sets, clears or writes one bit. Bit numbers below 80h land in the 16-byte bit area at RAM bytes 20h to 2Fh. Bit numbers from 80h up land in the SFRs whose address ends in 0h or 8h. Every bit operation is a read-modify-write of the whole target byte, which takes one extra cycle with `busy` high. When the target is an SFR, the block drives that read-modify-write on the SFR port. The mode of the access decides what an address means, so byte address 05h and bit address 05h are two different locations.

Top module: `bitram_core`

## Requirements
- R1: A byte request (`b_req`) with `b_we`=0 to an effective address below 80h returns that RAM byte on `b_rdata`, with `b_rvalid` high for exactly one cycle, after the clock edge that samples the request. A request with `b_we`=1 stores `b_wdata` at that edge.
- R2: A byte request to an effective address of 80h or above uses the SFR port and leaves the RAM unchanged. A read raises `sfr_re` with `sfr_addr` in the request cycle and returns the `sfr_rdata` of that cycle one cycle later. A write raises `sfr_we` with `sfr_addr` and `sfr_wdata` in the request cycle.
- R3: When `b_regrel`=1, the effective byte address is `bank_sel`*8 + `b_addr[2:0]`, and `b_addr[7:3]` is ignored. When `b_regrel`=0, the effective address is `b_addr`.
- R4: A bit address below 80h selects RAM byte 20h + `t_addr[6:3]` at bit position `t_addr[2:0]`. So bit 00h is bit 0 of byte 20h and bit 7Fh is bit 7 of byte 2Fh. This mapping is separate from byte addressing.
- R5: A bit address of 80h or above selects SFR byte `t_addr` AND F8h at bit `t_addr[2:0]`. The read-modify-write runs on the SFR port, and any `sfr_we` issued by it carries an address whose low three bits are zero.
- R6: `t_op` encoding: 0 = read, 1 = set, 2 = clear, 3 = write `t_wval`. Only the selected bit of the target byte changes. A read changes nothing.
- R7: A bit request is accepted when `t_req`=1 and `busy`=0. `busy` is high for exactly the one cycle after acceptance. `t_done` pulses for one cycle after that, with `t_rbit` equal to the selected bit's value before the operation.
- R8: While `busy`=1, `b_req` and `t_req` are ignored. They cause no write, no `b_rvalid` and no `t_done`.
- R9: A byte write and a bit request in the same idle cycle are both served. The byte write lands first, and the bit operation acts on the byte as just written.
- R10: Reset forces `busy`, `t_done` and `b_rvalid` low and does not alter the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Register bank used in register-relative mode |
| b_req | input | 1 | Byte access request |
| b_we | input | 1 | Byte access is a write |
| b_regrel | input | 1 | Byte address is a register number in the selected bank |
| b_addr | input | 8 | Byte direct address |
| b_wdata | input | 8 | Byte write data |
| b_rvalid | output | 1 | Byte read data valid |
| b_rdata | output | 8 | Byte read data |
| t_req | input | 1 | Bit operation request |
| t_op | input | 2 | Bit operation: read, set, clear, write |
| t_addr | input | 8 | Bit address |
| t_wval | input | 1 | Value used by the bit write operation |
| busy | output | 1 | Read-modify-write in progress |
| t_done | output | 1 | Bit operation complete |
| t_rbit | output | 1 | Bit value before the operation |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid in the cycle `sfr_re` is high |

## Verification
Byte reads are due one cycle after the request. The bench drives each request at a falling edge, and the monitor compares `b_rvalid`/`b_rdata` at the next falling edge. Bit results arrive two cycles after the request: `busy` is checked at the first falling edge, and `t_done`/`t_rbit` at the second. A scoreboard queues the expected bytes and bits in request order, in the same cycle as the stimulus. Any valid strobe that arrives when the queue holds nothing is reported, so a write or response leaking out during `busy` is caught at the cycle it appears.

// File: rtl/bitram_pkg.sv
package bitram_pkg;

    typedef enum logic [1:0] {
        BOP_READ  = 2'd0,
        BOP_SET   = 2'd1,
        BOP_CLR   = 2'd2,
        BOP_WRITE = 2'd3
    } bop_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RMW  = 1'b1
    } phase_e;

endpackage

// File: rtl/bitram_bytemap.sv
module bitram_bytemap #(
    parameter int ADDR_W     = 8,
    parameter int BANK_W     = 2,
    parameter int BANK_BYTES = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              regrel,
    input  logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              is_sfr
);
    localparam int REG_W = $clog2(BANK_BYTES);

    logic [ADDR_W-1:0] bank_base;
    logic [ADDR_W-1:0] reg_off;

    always_comb begin
        bank_base = ADDR_W'(bank) << REG_W;
        reg_off   = ADDR_W'(addr[REG_W-1:0]);
        eff_addr  = regrel ? (bank_base | reg_off) : addr;
        is_sfr    = eff_addr[ADDR_W-1];
    end
endmodule

// File: rtl/bitram_bitmap.sv
module bitram_bitmap #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int BITAREA_BASE = 32
) (
    input  logic [ADDR_W-1:0]         taddr,
    output logic                      is_sfr,
    output logic [ADDR_W-1:0]         byte_addr,
    output logic [$clog2(DATA_W)-1:0] bit_idx
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int GRP_W = ADDR_W - 1 - IDX_W;

    logic [GRP_W-1:0]  grp;
    logic [ADDR_W-1:0] ram_byte;
    logic [ADDR_W-1:0] sfr_byte;

    always_comb begin
        is_sfr    = taddr[ADDR_W-1];
        bit_idx   = taddr[IDX_W-1:0];
        grp       = taddr[ADDR_W-2:IDX_W];
        ram_byte  = ADDR_W'(BITAREA_BASE) + ADDR_W'(grp);
        sfr_byte  = {taddr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        byte_addr = is_sfr ? sfr_byte : ram_byte;
    end
endmodule

// File: rtl/bitram_bitalu.sv
module bitram_bitalu
    import bitram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]         old_byte,
    input  logic [$clog2(DATA_W)-1:0] idx,
    input  bop_e                      op,
    input  logic                      wval,
    output logic [DATA_W-1:0]         new_byte,
    output logic                      old_bit
);
    localparam int IDX_W = $clog2(DATA_W);

    logic target_val;

    always_comb begin
        unique case (op)
            BOP_SET:   target_val = 1'b1;
            BOP_CLR:   target_val = 1'b0;
            BOP_WRITE: target_val = wval;
            default:   target_val = old_byte[idx];
        endcase
        old_bit = old_byte[idx];
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign new_byte[i] = (idx == IDX_W'(i)) ? target_val : old_byte[i];
    end
endmodule

// File: rtl/bitram_array.sv
module bitram_array #(
    parameter int DATA_W = 8,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bitram_core.sv
module bitram_core
    import bitram_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int BANK_W       = 2,
    parameter int BANK_BYTES   = 8,
    parameter int BITAREA_BASE = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              b_req,
    input  logic              b_we,
    input  logic              b_regrel,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic              b_rvalid,
    output logic [DATA_W-1:0] b_rdata,
    input  logic              t_req,
    input  logic [1:0]        t_op,
    input  logic [ADDR_W-1:0] t_addr,
    input  logic              t_wval,
    output logic              busy,
    output logic              t_done,
    output logic              t_rbit,
    output logic              sfr_re,
    output logic              sfr_we,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);
    localparam int RAM_AW = ADDR_W - 1;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef struct packed {
        phase_e            ph;
        logic              tsfr;
        logic [ADDR_W-1:0] tbyte;
        logic [IDX_W-1:0]  tidx;
        bop_e              op;
        logic              wval;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              rbit;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        ph: PH_IDLE, tsfr: 1'b0, tbyte: '0, tidx: '0, op: BOP_READ,
        wval: 1'b0, rvalid: 1'b0, rdata: '0, done: 1'b0, rbit: 1'b0
    };

    ctl_t ctl_d, ctl_q;

    // byte-side decode
    logic [ADDR_W-1:0] b_eff;
    logic              b_is_sfr;

    bitram_bytemap #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_BYTES(BANK_BYTES)
    ) u_bytemap (
        .addr(b_addr), .regrel(b_regrel), .bank(bank_sel),
        .eff_addr(b_eff), .is_sfr(b_is_sfr)
    );

    // bit-side decode
    logic              t_is_sfr;
    logic [ADDR_W-1:0] t_byte;
    logic [IDX_W-1:0]  t_idx;

    bitram_bitmap #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BITAREA_BASE(BITAREA_BASE)
    ) u_bitmap (
        .taddr(t_addr), .is_sfr(t_is_sfr), .byte_addr(t_byte), .bit_idx(t_idx)
    );

    // storage
    logic              ram_we;
    logic [RAM_AW-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;
    logic [RAM_AW-1:0] ram_raddr;
    logic [DATA_W-1:0] ram_rdata;

    bitram_array #(.DATA_W(DATA_W), .AW(RAM_AW)) u_array (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    // modify stage
    logic [DATA_W-1:0] rmw_old;
    logic [DATA_W-1:0] rmw_new;
    logic              rmw_bit;

    bitram_bitalu #(.DATA_W(DATA_W)) u_bitalu (
        .old_byte(rmw_old), .idx(ctl_q.tidx), .op(ctl_q.op), .wval(ctl_q.wval),
        .new_byte(rmw_new), .old_bit(rmw_bit)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.rvalid = 1'b0;
        ctl_d.done   = 1'b0;

        ram_we    = 1'b0;
        ram_waddr = b_eff[RAM_AW-1:0];
        ram_wdata = b_wdata;
        ram_raddr = b_eff[RAM_AW-1:0];
        sfr_re    = 1'b0;
        sfr_we    = 1'b0;
        sfr_addr  = b_eff;
        sfr_wdata = b_wdata;
        rmw_old   = ram_rdata;

        if (ctl_q.ph == PH_IDLE) begin
            if (b_req) begin
                if (b_is_sfr) begin
                    if (b_we) begin
                        sfr_we = 1'b1;
                    end else begin
                        sfr_re       = 1'b1;
                        ctl_d.rvalid = 1'b1;
                        ctl_d.rdata  = sfr_rdata;
                    end
                end else begin
                    if (b_we) begin
                        ram_we = 1'b1;
                    end else begin
                        ctl_d.rvalid = 1'b1;
                        ctl_d.rdata  = ram_rdata;
                    end
                end
            end
            if (t_req) begin
                ctl_d.ph    = PH_RMW;
                ctl_d.tsfr  = t_is_sfr;
                ctl_d.tbyte = t_byte;
                ctl_d.tidx  = t_idx;
                ctl_d.op    = bop_e'(t_op);
                ctl_d.wval  = t_wval;
            end
        end else begin
            ram_raddr = ctl_q.tbyte[RAM_AW-1:0];
            ram_waddr = ctl_q.tbyte[RAM_AW-1:0];
            ram_wdata = rmw_new;
            sfr_addr  = ctl_q.tbyte;
            sfr_wdata = rmw_new;
            sfr_re    = ctl_q.tsfr;
            rmw_old   = ctl_q.tsfr ? sfr_rdata : ram_rdata;
            if (ctl_q.op != BOP_READ) begin
                ram_we = !ctl_q.tsfr;
                sfr_we = ctl_q.tsfr;
            end
            ctl_d.done = 1'b1;
            ctl_d.rbit = rmw_bit;
            ctl_d.ph   = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy     = (ctl_q.ph == PH_RMW);
    assign b_rvalid = ctl_q.rvalid;
    assign b_rdata  = ctl_q.rdata;
    assign t_done   = ctl_q.done;
    assign t_rbit   = ctl_q.rbit;

    // R7
    busy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R7
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_done |-> $past(busy));

    // R8
    rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_rvalid |-> $past(b_req && !b_we && !busy));

    // R5
    sfr_bit_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sfr_we) |-> (sfr_addr[IDX_W-1:0] == '0));

    // R6
    single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ram_we) |-> ($countones(ram_wdata ^ ram_rdata) <= 1));

    // R2
    sfr_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sfr_we) |-> !sfr_re);
endmodule

// File: tb/sim_bitram_core.sv
`timescale 1ns/1ps
module sim_bitram_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       b_req = 1'b0, b_we = 1'b0, b_regrel = 1'b0;
    logic [7:0] b_addr = '0, b_wdata = '0;
    logic       b_rvalid;
    logic [7:0] b_rdata;
    logic       t_req = 1'b0;
    logic [1:0] t_op = '0;
    logic [7:0] t_addr = '0;
    logic       t_wval = 1'b0;
    logic       busy, t_done, t_rbit;
    logic       sfr_re, sfr_we;
    logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;

    always #2 clk = ~clk;

    bitram_core u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .b_req(b_req), .b_we(b_we), .b_regrel(b_regrel), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rvalid(b_rvalid), .b_rdata(b_rdata),
        .t_req(t_req), .t_op(t_op), .t_addr(t_addr), .t_wval(t_wval),
        .busy(busy), .t_done(t_done), .t_rbit(t_rbit),
        .sfr_re(sfr_re), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // external SFR device
    logic [7:0] sfr_mem [256];
    assign sfr_rdata = sfr_mem[sfr_addr];
    always @(posedge clk) if (sfr_we) sfr_mem[sfr_addr] <= sfr_wdata;

    // reference model
    logic [7:0] ref_ram [128];
    logic [7:0] ref_sfr [256];

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t bq[$];
    exp_t tq[$];
    exp_t e;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] eff(logic [7:0] a, logic rr);
        return rr ? {3'b000, bank_sel, a[2:0]} : a;
    endfunction

    function automatic logic [7:0] ref_get(logic [7:0] a);
        return a[7] ? ref_sfr[a] : ref_ram[a[6:0]];
    endfunction

    task automatic ref_put(logic [7:0] a, logic [7:0] v);
        if (a[7]) ref_sfr[a] = v; else ref_ram[a[6:0]] = v;
    endtask

    function automatic logic [7:0] bit_byte(logic [7:0] t);
        return t[7] ? {t[7:3], 3'b000} : (8'h20 + {4'h0, t[6:3]});
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (b_rvalid) begin
                if (bq.size() == 0) check(1'b0, "R8 unexpected b_rvalid", b_rdata, 8'h00);
                else begin
                    e = bq.pop_front();
                    check(b_rdata == e.val, e.tag, b_rdata, e.val);
                end
            end
            if (t_done) begin
                if (tq.size() == 0) check(1'b0, "R8 unexpected t_done", {7'h0, t_rbit}, 8'h00);
                else begin
                    e = tq.pop_front();
                    check({7'h0, t_rbit} == e.val, e.tag, {7'h0, t_rbit}, e.val);
                end
            end
        end
    end

    task automatic byte_wr(logic [7:0] a, logic [7:0] v, logic rr);
        ref_put(eff(a, rr), v);
        b_req = 1; b_we = 1; b_addr = a; b_wdata = v; b_regrel = rr;
        @(negedge clk);
        b_req = 0; b_we = 0; b_regrel = 0;
    endtask

    task automatic byte_rd(logic [7:0] a, logic rr, string tag);
        bq.push_back('{val: ref_get(eff(a, rr)), tag: tag});
        b_req = 1; b_we = 0; b_addr = a; b_regrel = rr;
        @(negedge clk);
        b_req = 0; b_regrel = 0;
    endtask

    task automatic ref_bit(logic [7:0] ta, logic [1:0] op, logic wv, string tag);
        logic [7:0] ba = bit_byte(ta);
        logic [7:0] old = ref_get(ba);
        logic [7:0] nv = old;
        tq.push_back('{val: {7'h0, old[ta[2:0]]}, tag: tag});
        case (op)
            2'd1: nv[ta[2:0]] = 1'b1;
            2'd2: nv[ta[2:0]] = 1'b0;
            2'd3: nv[ta[2:0]] = wv;
            default: ;
        endcase
        ref_put(ba, nv);
    endtask

    task automatic bit_op(logic [7:0] ta, logic [1:0] op, logic wv, string tag);
        ref_bit(ta, op, wv, tag);
        t_req = 1; t_op = op; t_addr = ta; t_wval = wv;
        @(negedge clk);
        t_req = 0;
        check(busy == 1'b1, "R7 busy after accept", {7'h0, busy}, 8'h01);
        @(negedge clk);
        check(busy == 1'b0, "R7 busy one cycle", {7'h0, busy}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            sfr_mem[i] = 8'((i * 13) ^ 8'h5A);
            ref_sfr[i] = 8'((i * 13) ^ 8'h5A);
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy == 0, "R10 busy in reset", {7'h0, busy}, 8'h00);
        check(t_done == 0, "R10 t_done in reset", {7'h0, t_done}, 8'h00);
        check(b_rvalid == 0, "R10 b_rvalid in reset", {7'h0, b_rvalid}, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // fill RAM (R1)
        for (int i = 0; i < 128; i++) byte_wr(8'(i), 8'((i * 37) + 11), 1'b0);
        byte_rd(8'h00, 0, "R1 read 00");
        byte_rd(8'h45, 0, "R1 read 45");
        byte_rd(8'h7F, 0, "R1 read 7F");
        byte_wr(8'h45, 8'hC3, 0);
        byte_rd(8'h45, 0, "R1 read after write");

        // R2 SFR byte path
        byte_rd(8'h90, 0, "R2 sfr read 90");
        byte_wr(8'h85, 8'h3C, 0);
        check(sfr_mem[8'h85] == 8'h3C, "R2 sfr write", sfr_mem[8'h85], 8'h3C);
        byte_rd(8'h05, 0, "R2 ram untouched by sfr write");
        byte_rd(8'h85, 0, "R2 sfr readback");

        // R3 register-relative
        bank_sel = 2'd2;
        byte_wr(8'hF3, 8'hA7, 1'b1);
        byte_rd(8'h13, 0, "R3 bank2 r3 is byte 13");
        bank_sel = 2'd3;
        byte_wr(8'h07, 8'h19, 1'b1);
        byte_rd(8'h1F, 0, "R3 bank3 r7 is byte 1F");
        byte_rd(8'h07, 0, "R3 byte 07 untouched");
        bank_sel = 2'd0;
        byte_rd(8'h03, 1'b1, "R3 bank0 r3");

        // R4 RAM bit area
        byte_wr(8'h20, 8'h00, 0);
        byte_wr(8'h2F, 8'h00, 0);
        bit_op(8'h00, 2'd1, 0, "R4 set bit 00 old");
        byte_rd(8'h20, 0, "R4 bit 00 is LSB of 20");
        bit_op(8'h7F, 2'd1, 0, "R4 set bit 7F old");
        byte_rd(8'h2F, 0, "R4 bit 7F is MSB of 2F");
        bit_op(8'h05, 2'd0, 0, "R4 bit 05 read");
        byte_rd(8'h05, 0, "R4 byte 05 distinct from bit 05");

        // R6 ops
        byte_wr(8'h24, 8'h5A, 0);
        bit_op(8'h21, 2'd2, 0, "R6 clear old");
        bit_op(8'h21, 2'd0, 0, "R6 read after clear");
        bit_op(8'h20, 2'd3, 1, "R6 write 1 old");
        bit_op(8'h26, 2'd3, 0, "R6 write 0 old");
        bit_op(8'h27, 2'd0, 0, "R6 read only");
        byte_rd(8'h24, 0, "R6 only selected bits changed");

        // R5 SFR bits
        bit_op(8'h93, 2'd1, 0, "R5 set sfr 90 bit3 old");
        byte_rd(8'h90, 0, "R5 sfr 90 after set");
        bit_op(8'hFF, 2'd2, 0, "R5 clear sfr F8 bit7 old");
        byte_rd(8'hF8, 0, "R5 sfr F8 after clear");
        bit_op(8'h8A, 2'd3, 1, "R5 write sfr 88 bit2 old");
        check(sfr_mem[8'h88] == ref_sfr[8'h88], "R5 sfr 88 content",
              sfr_mem[8'h88], ref_sfr[8'h88]);

        // R8 requests ignored while busy
        ref_bit(8'h30, 2'd1, 0, "R8 first op old");
        t_req = 1; t_op = 2'd1; t_addr = 8'h30;
        @(negedge clk);
        b_req = 1; b_we = 1; b_addr = 8'h40; b_wdata = 8'hEE;
        t_op = 2'd2; t_addr = 8'h31;
        @(negedge clk);
        b_req = 0; b_we = 0; t_req = 0;
        @(negedge clk);
        byte_rd(8'h40, 0, "R8 byte write during busy dropped");
        byte_rd(8'h26, 0, "R8 bit op during busy dropped");

        // R9 same-cycle byte write and bit op
        ref_put(8'h22, 8'h00);
        ref_bit(8'h10, 2'd1, 0, "R9 bit sees new byte");
        b_req = 1; b_we = 1; b_addr = 8'h22; b_wdata = 8'h00;
        t_req = 1; t_op = 2'd1; t_addr = 8'h10;
        @(negedge clk);
        b_req = 0; b_we = 0; t_req = 0;
        @(negedge clk);
        byte_rd(8'h22, 0, "R9 byte after both");

        // R10 reset keeps RAM
        byte_wr(8'h33, 8'h5C, 0);
        rst_n = 0;
        repeat (2) @(negedge clk);
        check(b_rvalid == 0 && busy == 0, "R10 outputs low in reset", {6'h0, b_rvalid, busy}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        byte_rd(8'h33, 0, "R10 RAM kept over reset");

        repeat (3) @(negedge clk);
        check(bq.size() == 0, "R1 byte queue drained", 8'(bq.size()), 8'h00);
        check(tq.size() == 0, "R7 bit queue drained", 8'(tq.size()), 8'h00);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule